// File: doc/BRIEF.md
# Configurable SPI Controller Core

This block is a synchronous serial port that can act either as the clock-driving end of a link (master) or as the clocked end (slave). Software controls it through a four-address register port. It writes transmit words into a small queue and reads received words back. A sticky completion flag, with a mask, drives an interrupt line. Words of 8, 16, 9 or 32 bits are shifted most-significant bit first in SPI mode 0: data is launched after a falling SCK edge and captured on the rising edge.

In master mode the block starts a transfer by itself whenever the queue holds a word, and generates SCK at a quarter of the system clock. In slave mode it synchronizes the external SCK, slave-select and data-in pins to the system clock. It shifts one bit per external edge. It takes its next outgoing word from the queue at each word boundary, and sends zeros when the queue is empty.

Several test and bring-up aids are included:
- a forced level on the data-out pin;
- a soft reset that stops the serial engine while the synchronizers keep running;
- a readback of the synchronized data-in pin.

Top module: `spi_ctl_core`

## Requirements
- R1: After reset, the control word at address 0 reads 0x0000 (with din_i low), int_o is 0, sck_o is 0 and the queue is not full. The block is therefore an 8-bit slave with the interrupt masked.
- R2: Control bits [2:1] select the word length: 00 = 8, 01 = 16, 10 = 32, 11 = 9 bits. In master mode (control bit 0 = 1) exactly that many SCK pulses occur, and dout_o carries the word MSB first.
- R3: Size code 11 is honoured only in master mode. In slave mode it behaves as an 8-bit word.
- R4: A write to address 1 queues a word, and in 8, 9 and 16-bit modes the word is that write's data. In 32-bit mode the word's upper half is the last value written to address 2. A received word reads back with its low half at address 1 and its high half at address 2, and the high half is 0 for words of 16 bits or fewer.
- R5: The completion flag (read at control bit 9) sets when a word has been both sent and received. It stays set until any write to address 3.
- R6: int_o is the completion flag gated by control bit 3. The flag still sets while the mask bit is 0.
- R7: Control bit 10 reads the level of din_i after a two-stage synchronizer.
- R8: Control bit 8 reads 1 when the 2-entry transmit queue is full. A data write while it is 1 is dropped.
- R9: While control bit 4 is 1, dout_o equals control bit 5 instead of the shift register.
- R10: While control bit 6 is 1, the serial engine is held idle, sck_o stays low, the queue is emptied and data writes are dropped. The din_i readback keeps tracking the pin.
- R11: In slave mode with control bit 7 = 1, SCK edges are ignored while ss_n_i is high. With bit 7 = 0, ss_n_i has no effect.
- R12: In master mode SCK has a period of 4 system clocks, and a transfer begins without further action once the queue is non-empty. din_i is captured on each rising SCK edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 data low, 2 data high, 3 flag clear |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for the address of the previous cycle |
| int_o | output | 1 | Masked completion interrupt |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| ss_n_i | input | 1 | Active-low slave select |
| dout_o | output | 1 | Serial data out |
| din_i | input | 1 | Serial data in |

## Verification
The bench builds the block with its defaults: a 2-entry queue and an SCK divide of 4. The shallow queue lets three writes in slave mode fill it, with one word held in the shift register, so the full flag and a dropped fourth word can be reached within a few cycles. The divide of 4 keeps a 32-bit master transfer near 130 cycles, which leaves room for a seeded random sweep over all four size codes. In master mode the bench feeds the inverse of dout_o back into din_i, so every bit sent also tests the receive path.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {
    SZ_8  = 2'b00,
    SZ_16 = 2'b01,
    SZ_32 = 2'b10,
    SZ_9  = 2'b11
  } size_code_e;

  // Bit count for a size code; the 9-bit code only applies to the master role.
  function automatic logic [LEN_W-1:0] word_len(input logic [1:0] code, input logic is_master);
    case (size_code_e'(code))
      SZ_8:    return LEN_W'(8);
      SZ_16:   return LEN_W'(16);
      SZ_32:   return LEN_W'(32);
      default: return is_master ? LEN_W'(9) : LEN_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/spi_tx_fifo.sv
module spi_tx_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R8: occupancy never passes the depth
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(DEPTH));
  // R8: the engine only takes a word when one is queued
  p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_ctl_pkg::*;
#(
  parameter int SCK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              srst,
  input  logic              master,
  input  logic [LEN_W-1:0]  wlen,
  input  logic              ss_gate,
  input  logic              force_en,
  input  logic              force_lvl,
  input  logic              sck_i,
  input  logic              ss_n_i,
  input  logic              din_i,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_word,
  output logic              fifo_pop,
  output logic              sck_o,
  output logic              dout_o,
  output logic              din_sync,
  output logic              done,
  output logic [WORD_W-1:0] rx_word
);
  localparam int DIV_W = (SCK_DIV > 2) ? $clog2(SCK_DIV) : 1;
  localparam int HALF  = SCK_DIV / 2;

  logic [1:0]        din_sr, sck_sr, ss_sr;
  logic              sck_d, sck_rise, sck_fall, sl_hold;
  logic              busy, loaded, sck_q, start_m, start_s, last;
  logic [DIV_W-1:0]  div;
  logic [LEN_W-1:0]  bitcnt, shamt;
  logic [WORD_W-1:0] tx_sh, rx_sh, aligned;

  assign din_sync = din_sr[1];
  assign sck_rise = sck_sr[1] && !sck_d;
  assign sck_fall = !sck_sr[1] && sck_d;
  assign sl_hold  = ss_gate && ss_sr[1];
  assign shamt    = LEN_W'(WORD_W) - wlen;
  assign aligned  = fifo_word << shamt;
  assign last     = (LEN_W'(bitcnt + 1'b1) == wlen);
  assign start_m  = master && !busy && !fifo_empty && !srst;
  assign start_s  = !master && !srst && !sl_hold && !loaded && (bitcnt == '0) && !fifo_empty;
  assign fifo_pop = start_m || start_s;
  assign sck_o    = sck_q;
  assign dout_o   = force_en ? force_lvl : tx_sh[WORD_W-1];

  // Synchronizers keep running through soft reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      din_sr <= '0;
      sck_sr <= '0;
      ss_sr  <= 2'b11;
      sck_d  <= 1'b0;
    end else begin
      din_sr <= {din_sr[0], din_i};
      sck_sr <= {sck_sr[0], sck_i};
      ss_sr  <= {ss_sr[0], ss_n_i};
      sck_d  <= sck_sr[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      busy    <= 1'b0;
      loaded  <= 1'b0;
      sck_q   <= 1'b0;
      div     <= '0;
      bitcnt  <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_word <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (master) begin
        loaded <= 1'b0;
        if (!busy) begin
          sck_q <= 1'b0;
          div   <= '0;
          if (start_m) begin
            busy   <= 1'b1;
            tx_sh  <= aligned;
            rx_sh  <= '0;
            bitcnt <= '0;
          end
        end else begin
          div <= (div == DIV_W'(SCK_DIV - 1)) ? '0 : div + 1'b1;
          if (div == DIV_W'(HALF - 1)) begin
            sck_q <= 1'b1;
            rx_sh <= {rx_sh[WORD_W-2:0], din_i};
          end
          if (div == DIV_W'(SCK_DIV - 1)) begin
            sck_q <= 1'b0;
            tx_sh <= tx_sh << 1;
            if (last) begin
              busy    <= 1'b0;
              done    <= 1'b1;
              rx_word <= rx_sh;
              bitcnt  <= '0;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
      end else begin
        busy  <= 1'b0;
        sck_q <= 1'b0;
        div   <= '0;
        if (sl_hold) begin
          bitcnt <= '0;
          rx_sh  <= '0;
        end else begin
          if (start_s) begin
            tx_sh  <= aligned;
            loaded <= 1'b1;
          end
          if (sck_rise) begin
            if (last) begin
              done    <= 1'b1;
              rx_word <= {rx_sh[WORD_W-2:0], din_sr[1]};
              rx_sh   <= '0;
              tx_sh   <= '0;
              bitcnt  <= '0;
              loaded  <= 1'b0;
            end else begin
              rx_sh  <= {rx_sh[WORD_W-2:0], din_sr[1]};
              bitcnt <= bitcnt + 1'b1;
            end
          end else if (sck_fall && bitcnt != '0) begin
            tx_sh <= tx_sh << 1;
          end
        end
      end
    end
  end

  // R10: soft reset leaves the engine idle with the clock low
  p_srst_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    srst |=> (!sck_o && !busy));
  // R12: a master SCK high phase lasts at least two system clocks
  p_sck_high_r12: assert property (@(posedge clk) disable iff (rst)
    ($rose(sck_o) && master && !srst) |=> (sck_o || !master || srst));
endmodule

// File: rtl/spi_ctl_core.sv
module spi_ctl_core
  import spi_ctl_pkg::*;
#(
  parameter int FIFO_DEPTH = 2,
  parameter int SCK_DIV    = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        int_o,
  output logic        sck_o,
  input  logic        sck_i,
  input  logic        ss_n_i,
  output logic        dout_o,
  input  logic        din_i
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_LO   = 2'd1;
  localparam logic [1:0] A_HI   = 2'd2;
  localparam logic [1:0] A_CLR  = 2'd3;

  logic [7:0]        ctrl_q;
  logic [15:0]       hi_stage, rx_lo, rx_hi;
  logic              flag_q, fifo_full, fifo_empty, fifo_pop, push;
  logic              eng_done, din_sync, clr_wr;
  logic [WORD_W-1:0] push_word, fifo_word, rx_word;
  logic [LEN_W-1:0]  wlen;

  wire master  = ctrl_q[0];
  wire mask_en = ctrl_q[3];
  wire srst    = ctrl_q[6];

  assign wlen      = word_len(ctrl_q[2:1], master);
  assign clr_wr    = reg_wr && (reg_addr == A_CLR);
  assign push      = reg_wr && (reg_addr == A_LO) && !fifo_full && !srst;
  assign push_word = (ctrl_q[2:1] == SZ_32) ? {hi_stage, reg_wdata} : {16'h0000, reg_wdata};
  assign int_o     = flag_q && mask_en;

  spi_tx_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(srst), .push(push), .wdata(push_word),
    .pop(fifo_pop), .rdata(fifo_word), .empty(fifo_empty), .full(fifo_full)
  );

  spi_shift_engine #(.SCK_DIV(SCK_DIV)) u_eng (
    .clk(clk), .rst(rst), .srst(srst), .master(master), .wlen(wlen),
    .ss_gate(ctrl_q[7]), .force_en(ctrl_q[4]), .force_lvl(ctrl_q[5]),
    .sck_i(sck_i), .ss_n_i(ss_n_i), .din_i(din_i),
    .fifo_empty(fifo_empty), .fifo_word(fifo_word), .fifo_pop(fifo_pop),
    .sck_o(sck_o), .dout_o(dout_o), .din_sync(din_sync),
    .done(eng_done), .rx_word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      hi_stage  <= '0;
      rx_lo     <= '0;
      rx_hi     <= '0;
      flag_q    <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) ctrl_q   <= reg_wdata[7:0];
      if (reg_wr && reg_addr == A_HI)   hi_stage <= reg_wdata;
      if (eng_done) begin
        rx_lo  <= rx_word[15:0];
        rx_hi  <= rx_word[31:16];
        flag_q <= 1'b1;
      end else if (clr_wr) begin
        flag_q <= 1'b0;
      end
      case (reg_addr)
        A_CTRL:  reg_rdata <= {5'b0, din_sync, flag_q, fifo_full, ctrl_q};
        A_LO:    reg_rdata <= rx_lo;
        A_HI:    reg_rdata <= rx_hi;
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R5: the flag holds until a clear write
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_wr) |=> flag_q);
  // R6: an unmasked completion raises the interrupt line
  p_irq_raise_r6: assert property (@(posedge clk) disable iff (rst)
    (eng_done && mask_en && !(reg_wr && reg_addr == A_CTRL)) |=> int_o);
endmodule

// File: tb/spi_ctl_core_tb.sv
`timescale 1ns/1ps
module spi_ctl_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        int_o, sck_o, dout_o, din_i;
  logic        sck_i = 1'b0;
  logic        ss_n_i = 1'b1;
  logic        din_drv = 1'b0;
  logic        loop_en = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [31:0] cap = '0;
  int          rise_cnt = 0;
  time         t_prev = 0, t_last = 0;

  always #10 clk = ~clk;

  assign din_i = loop_en ? ~dout_o : din_drv;

  spi_ctl_core dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_o(int_o),
    .sck_o(sck_o), .sck_i(sck_i), .ss_n_i(ss_n_i), .dout_o(dout_o), .din_i(din_i)
  );

  always @(posedge sck_o) begin
    cap      <= {cap[30:0], dout_o};
    rise_cnt <= rise_cnt + 1;
    t_prev   <= t_last;
    t_last   <= $time;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int blen(input logic [1:0] code, input bit mst);
    case (code)
      2'b00: return 8;
      2'b01: return 16;
      2'b10: return 32;
      default: return mst ? 9 : 8;
    endcase
  endfunction

  function automatic logic [31:0] lmask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  function automatic logic [15:0] mkctl(input bit mst, input logic [1:0] code, input bit msk,
                                        input bit fen, input bit lvl, input bit sr, input bit gate);
    return {8'h00, gate, sr, lvl, fen, msk, code, mst};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_int(input int lim, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < lim && !seen; i++) begin
      @(negedge clk);
      if (int_o) seen = 1'b1;
    end
  endtask

  // Master transfer with loopback: din = ~dout, so the received word is the inverse.
  task automatic mx(input logic [15:0] ctl, input logic [31:0] word,
                    input logic [31:0] exp_tx, input string tag);
    int n, r0;
    bit seen;
    logic [31:0] m, rx;
    logic [15:0] d;
    n = blen(ctl[2:1], 1'b1);
    m = lmask(n);
    loop_en = 1'b1;
    wr(2'd0, ctl);
    r0 = rise_cnt;
    if (ctl[2:1] == 2'b10) wr(2'd2, word[31:16]);
    wr(2'd1, word[15:0]);
    wait_int(600, seen);
    check({tag, " R5 flag raised"}, 32'(seen), 32'd1);
    check({tag, " R2 pulse count"}, 32'(rise_cnt - r0), 32'(n));
    check({tag, " R2 bits MSB first"}, cap & m, exp_tx);
    check({tag, " R12 sck period"}, 32'(t_last - t_prev), 32'd80);
    rx = ~exp_tx & m;
    rd(2'd1, d);
    check({tag, " R4 rx low"}, 32'(d), 32'(rx[15:0]));
    rd(2'd2, d);
    check({tag, " R4 rx high"}, 32'(d), 32'(rx[31:16]));
    wr(2'd3, 16'h0);
    @(negedge clk);
    check({tag, " R5 clear"}, 32'(int_o), 32'd0);
  endtask

  // Bench acts as master toward the slave-mode block.
  task automatic sx(input int n, input logic [31:0] bits, output logic [31:0] got);
    got = '0;
    for (int i = n - 1; i >= 0; i--) begin
      din_drv = bits[i];
      repeat (8) @(negedge clk);
      got = {got[30:0], dout_o};
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] d;
    logic [31:0] got, w;
    bit seen;
    int r0;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d);
    check("R1 ctrl after reset", 32'(d), 32'h0);
    check("R1 int_o after reset", 32'(int_o), 32'd0);
    check("R1 sck_o after reset", 32'(sck_o), 32'd0);

    // R2/R4 directed master sizes
    mx(mkctl(1, 2'b00, 1, 0, 0, 0, 0), 32'h0000_00A5, 32'h0000_00A5, "dir8");
    mx(mkctl(1, 2'b01, 1, 0, 0, 0, 0), 32'h0000_8001, 32'h0000_8001, "dir16");
    mx(mkctl(1, 2'b11, 1, 0, 0, 0, 0), 32'h0000_0155, 32'h0000_0155, "dir9");
    mx(mkctl(1, 2'b10, 1, 0, 0, 0, 0), 32'hDEAD_BEEF, 32'hDEAD_BEEF, "dir32");

    // R2/R4/R12 random master sweep
    for (int k = 0; k < 12; k++) begin
      logic [1:0] code;
      logic [31:0] wd;
      code = 2'($urandom % 4);
      w = $urandom;
      wd = (code == 2'b10) ? w : {16'h0, w[15:0]};
      mx(mkctl(1, code, 1, 0, 0, 0, 0), wd, wd & lmask(blen(code, 1'b1)), "rnd");
    end

    // R9 force output level
    wr(2'd0, mkctl(1, 2'b00, 1, 1, 1, 0, 0));
    @(negedge clk);
    check("R9 forced high", 32'(dout_o), 32'd1);
    mx(mkctl(1, 2'b00, 1, 1, 1, 0, 0), 32'h0, 32'h0000_00FF, "R9 force1");
    mx(mkctl(1, 2'b00, 1, 1, 0, 0, 0), 32'h00FF, 32'h0, "R9 force0");

    // R10 soft reset, R7 din readback
    loop_en = 1'b0;
    wr(2'd0, mkctl(1, 2'b00, 1, 0, 0, 1, 0));
    r0 = rise_cnt;
    wr(2'd1, 16'h0011); wr(2'd1, 16'h0022); wr(2'd1, 16'h0033);
    repeat (100) @(negedge clk);
    check("R10 no sck in soft reset", 32'(rise_cnt - r0), 32'd0);
    check("R10 no interrupt", 32'(int_o), 32'd0);
    rd(2'd0, d);
    check("R10 queue not full", 32'(d[8]), 32'd0);
    din_drv = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd0, d);
    check("R7 din readback high", 32'(d[10]), 32'd1);
    din_drv = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd0, d);
    check("R7 din readback low", 32'(d[10]), 32'd0);
    wr(2'd0, mkctl(1, 2'b00, 1, 0, 0, 0, 0));
    repeat (60) @(negedge clk);
    check("R10 writes dropped", 32'(rise_cnt - r0), 32'd0);

    // Slave 8-bit, R2 in slave role
    wr(2'd0, mkctl(0, 2'b00, 1, 0, 0, 0, 0));
    wr(2'd1, 16'h00A5);
    sx(8, 32'h3C, got);
    check("R2 slave tx", got, 32'hA5);
    check("R5 slave flag", 32'(int_o), 32'd1);
    rd(2'd1, d);
    check("R4 slave rx low", 32'(d), 32'h3C);
    wr(2'd3, 16'h0);

    // R3 size 11 as 8 bits in slave
    wr(2'd0, mkctl(0, 2'b11, 1, 0, 0, 0, 0));
    wr(2'd1, 16'h01A5);
    sx(8, 32'h77, got);
    check("R3 slave 9-bit code sends 8", got, 32'hA5);
    check("R3 done after 8 bits", 32'(int_o), 32'd1);
    rd(2'd1, d);
    check("R3 rx", 32'(d), 32'h77);
    wr(2'd3, 16'h0);

    // R6 masked flag
    wr(2'd0, mkctl(0, 2'b00, 0, 0, 0, 0, 0));
    wr(2'd1, 16'h0081);
    sx(8, 32'h18, got);
    check("R6 masked int_o", 32'(int_o), 32'd0);
    rd(2'd0, d);
    check("R6 flag still set", 32'(d[9]), 32'd1);
    wr(2'd3, 16'h0);
    rd(2'd0, d);
    check("R5 flag cleared", 32'(d[9]), 32'd0);

    // R8 queue full and dropped write
    wr(2'd0, mkctl(0, 2'b00, 1, 0, 0, 0, 0));
    wr(2'd1, 16'h0011); wr(2'd1, 16'h0022); wr(2'd1, 16'h0033);
    rd(2'd0, d);
    check("R8 full flag", 32'(d[8]), 32'd1);
    wr(2'd1, 16'h0044);
    sx(8, 32'h0, got);
    check("R8 word1", got, 32'h11);
    wr(2'd3, 16'h0);
    rd(2'd0, d);
    check("R8 space after drain", 32'(d[8]), 32'd0);
    sx(8, 32'h0, got);
    check("R8 word2", got, 32'h22);
    sx(8, 32'h0, got);
    check("R8 word3", got, 32'h33);
    sx(8, 32'h0, got);
    check("R8 dropped write absent", got, 32'h00);
    wr(2'd3, 16'h0);

    // R11 slave select gating
    wr(2'd0, mkctl(0, 2'b00, 1, 0, 0, 0, 1));
    ss_n_i = 1'b1;
    wr(2'd1, 16'h005A);
    sx(8, 32'hFF, got);
    check("R11 gated: no completion", 32'(int_o), 32'd0);
    ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    sx(8, 32'h0F, got);
    check("R11 selected tx", got, 32'h5A);
    wait_int(4, seen);
    check("R11 selected flag", 32'(seen), 32'd1);
    wr(2'd3, 16'h0);
    ss_n_i = 1'b1;
    wr(2'd0, mkctl(0, 2'b00, 1, 0, 0, 0, 0));
    wr(2'd1, 16'h00C3);
    sx(8, 32'h0, got);
    check("R11 ungated ignores ss", got, 32'hC3);
    check("R11 ungated flag", 32'(int_o), 32'd1);
    wr(2'd3, 16'h0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule